// File: doc/BRIEF.md
# Double-Buffered Raster Scanout with Pixel Doubling

This block drives a raster display from a pixel clock. Two counters track the horizontal and vertical position. Comparisons on those counters produce active-low horizontal and vertical sync and a display-enable window. A stored image of half the visible width and half the visible height is read from a synchronous dual-port frame store. Each stored pixel is shown on two adjacent columns, and each stored line is shown on two adjacent rows. With the default 640x480 timing, this maps a 320x240 image onto the full active area. Every pixel word is 9 bits wide and carries three 3-bit colour codes. These codes leave the block for an external resistor ladder.

The frame store holds two images in separate banks, selected by the top address bit. Scanout reads the shown bank while a renderer, outside this block, fills the other bank. The renderer asks for a swap with a one-cycle request. The request is held until the first clock of vertical blank. At that clock the shown bank flips and a one-cycle acknowledge is raised.

A small bank state machine has two states. Idle means no swap is waiting. Armed means a swap is waiting. The block takes the transition Idle to Armed when a request arrives away from the blank boundary. It takes the transition Armed to Idle at the boundary, and the bank flips. A request that arrives exactly at the boundary flips the bank at once, and the machine stays in Idle.

Top module: `vga_scanout`

## Requirements
- R1: While reset is held: hsync_n and vsync_n are 1, de is 0, all colour outputs are 0, swap_ack is 0, show_bank is 0 and fb_addr is 0.
- R2: A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks. hsync_n is low for exactly H_SYNC clocks, starting H_VIS+H_FP clocks after the first visible pixel of the line.
- R3: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines. vsync_n is low for exactly V_SYNC lines, starting V_VIS+V_FP lines after the first visible line.
- R4: de is high exactly during the first H_VIS pixels of each of the first V_VIS lines. Outside that window, red, green and blue are 0.
- R5: Inside the window, red is the pixel word's bits [8:6], green is bits [5:3] and blue is bits [2:0]. The word used is the one returned for the address issued one clock earlier, so colour, de and both syncs refer to the same raster position.
- R6: fb_ren is high exactly when the counters are inside the active window. In that case, fb_addr[IW-1:0] equals (line/2)*(H_VIS/2) + pixel/2. As a result, the index advances after every second pixel, and each source line is reloaded at its start for the repeated display row.
- R7: fb_addr[IW] equals show_bank. show_bank changes only in a cycle where swap_ack is high.
- R8: A swap request is held until the first clock of vertical blank (pixel 0 of line V_VIS). At that clock show_bank toggles and swap_ack is high for one cycle. Several requests within one frame produce a single swap. A request sampled on the edge that enters blank takes effect at that boundary.
- R9: swap_ack is never high at any other position. With no request since the last swap, the boundary passes with no acknowledge and no bank change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| swap_req | input | 1 | One-cycle request to show the other bank |
| swap_ack | output | 1 | One-cycle pulse when the shown bank flips |
| show_bank | output | 1 | Bank currently read by scanout |
| fb_addr | output | IW+1 | Frame-store read address, bank in the MSB |
| fb_ren | output | 1 | Read enable, high while a displayed pixel is fetched |
| fb_data | input | 3*COLOR_BITS | Pixel word returned one clock after its address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable |
| red | output | COLOR_BITS | Red code |
| green | output | COLOR_BITS | Green code |
| blue | output | COLOR_BITS | Blue code |

## Verification
The assertions check several things on every cycle:
- the length of every horizontal and vertical sync pulse and the spacing between horizontal sync pulses;
- black output whenever de is low;
- the address index moving by at most one between consecutive fetches;
- the bank bit changing only together with an acknowledge;
- the acknowledge appearing only at the first clock of vertical blank.

The bench scenarios cover what these checks cannot:
- the exact address of every fetch, including the reload on doubled rows;
- the colour fields of every pixel;
- the total line and frame counts;
- the ordering cases of swap requests: a request mid-frame, two requests in one frame, a request on the boundary edge itself, a request during blank, and a frame with no request.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

    // Bank-swap controller states
    typedef enum logic {
        SWP_IDLE  = 1'b0,
        SWP_ARMED = 1'b1
    } swap_state_e;

endpackage

// File: rtl/vga_timing.sv
module vga_timing #(
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
    localparam int HW    = $clog2(H_TOT),
    localparam int VW    = $clog2(V_TOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          h_act,
    output logic          v_act,
    output logic          h_last_vis,
    output logic          vbl_start,
    output logic          frame_end,
    output logic          hs_n,
    output logic          vs_n
);

    localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
    localparam logic [HW-1:0] HS_ON  = HW'(H_VIS + H_FP);
    localparam logic [HW-1:0] HS_OFF = HW'(H_VIS + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_ON  = VW'(V_VIS + V_FP);
    localparam logic [VW-1:0] VS_OFF = VW'(V_VIS + V_FP + V_SYNC);

    logic line_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (line_end) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    always_comb begin
        line_end   = (h_cnt == H_LAST);
        h_act      = (h_cnt < HW'(H_VIS));
        v_act      = (v_cnt < VW'(V_VIS));
        h_last_vis = (h_cnt == HW'(H_VIS - 1));
        vbl_start  = line_end && (v_cnt == VW'(V_VIS - 1));
        frame_end  = line_end && (v_cnt == V_LAST);
        hs_n       = !((h_cnt >= HS_ON) && (h_cnt < HS_OFF));
        vs_n       = !((v_cnt >= VS_ON) && (v_cnt < VS_OFF));
    end

endmodule

// File: rtl/vga_addr_gen.sv
module vga_addr_gen #(
    parameter int SRC_W = 320,
    parameter int IW    = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_act,
    input  logic          v_act,
    input  logic          h_last_vis,
    input  logic          frame_end,
    input  logic          h_lsb,
    input  logic          v_lsb,
    output logic [IW-1:0] idx,
    output logic          ren
);

    localparam logic [IW-1:0] STEP = IW'(SRC_W);

    logic [IW-1:0] line_base;

    assign ren = h_act && v_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base <= '0;
            idx       <= '0;
        end else if (frame_end) begin
            line_base <= '0;
            idx       <= '0;
        end else if (ren && h_last_vis) begin
            if (v_lsb) begin
                line_base <= line_base + STEP;
                idx       <= line_base + STEP;
            end else begin
                idx       <= line_base;
            end
        end else if (ren && h_lsb) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/vga_bank_ctl.sv
module vga_bank_ctl
    import vga_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic vbl_start,
    output logic show_bank,
    output logic swap_ack
);

    swap_state_e state, state_nx;
    logic        flip;

    assign flip = vbl_start && ((state == SWP_ARMED) || swap_req);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SWP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SWP_IDLE:  if (swap_req && !vbl_start) state_nx = SWP_ARMED;
            SWP_ARMED: if (vbl_start)              state_nx = SWP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            show_bank <= 1'b0;
            swap_ack  <= 1'b0;
        end else begin
            swap_ack <= flip;
            if (flip) show_bank <= ~show_bank;
        end
    end

endmodule

// File: rtl/vga_scanout.sv
module vga_scanout
    import vga_scan_pkg::*;
#(
    parameter int H_VIS      = 640,
    parameter int H_FP       = 16,
    parameter int H_SYNC     = 96,
    parameter int H_BP       = 48,
    parameter int V_VIS      = 480,
    parameter int V_FP       = 10,
    parameter int V_SYNC     = 2,
    parameter int V_BP       = 33,
    parameter int COLOR_BITS = 3,
    localparam int PIX_W = 3 * COLOR_BITS,
    localparam int SRC_W = H_VIS / 2,
    localparam int SRC_H = V_VIS / 2,
    localparam int IW    = $clog2(SRC_W * SRC_H)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  swap_req,
    output logic                  swap_ack,
    output logic                  show_bank,
    output logic [IW:0]           fb_addr,
    output logic                  fb_ren,
    input  logic [PIX_W-1:0]      fb_data,
    output logic                  hsync_n,
    output logic                  vsync_n,
    output logic                  de,
    output logic [COLOR_BITS-1:0] red,
    output logic [COLOR_BITS-1:0] green,
    output logic [COLOR_BITS-1:0] blue
);

    localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);

    logic [HW-1:0]    h_cnt;
    logic [VW-1:0]    v_cnt;
    logic             h_act, v_act, h_last_vis, vbl_start, frame_end;
    logic             hs_n, vs_n;
    logic [IW-1:0]    idx;
    logic [PIX_W-1:0] pix_out;

    vga_timing #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_cnt      (h_cnt),
        .v_cnt      (v_cnt),
        .h_act      (h_act),
        .v_act      (v_act),
        .h_last_vis (h_last_vis),
        .vbl_start  (vbl_start),
        .frame_end  (frame_end),
        .hs_n       (hs_n),
        .vs_n       (vs_n)
    );

    vga_addr_gen #(
        .SRC_W(SRC_W), .IW(IW)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_act      (h_act),
        .v_act      (v_act),
        .h_last_vis (h_last_vis),
        .frame_end  (frame_end),
        .h_lsb      (h_cnt[0]),
        .v_lsb      (v_cnt[0]),
        .idx        (idx),
        .ren        (fb_ren)
    );

    vga_bank_ctl u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_req  (swap_req),
        .vbl_start (vbl_start),
        .show_bank (show_bank),
        .swap_ack  (swap_ack)
    );

    assign fb_addr = {show_bank, idx};

    // Sync and enable delayed one clock to line up with the read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            de      <= 1'b0;
        end else begin
            hsync_n <= hs_n;
            vsync_n <= vs_n;
            de      <= fb_ren;
        end
    end

    for (genvar ch = 0; ch < 3; ch++) begin : g_blank
        assign pix_out[ch*COLOR_BITS +: COLOR_BITS] =
            de ? fb_data[ch*COLOR_BITS +: COLOR_BITS] : '0;
    end

    assign red   = pix_out[2*COLOR_BITS +: COLOR_BITS];
    assign green = pix_out[COLOR_BITS +: COLOR_BITS];
    assign blue  = pix_out[0 +: COLOR_BITS];

endmodule

// File: rtl/vga_scanout_chk.sv
module vga_scanout_chk #(
    parameter int H_TOT  = 800,
    parameter int H_SYNC = 96,
    parameter int V_SYNC = 2,
    parameter int V_VIS  = 480,
    parameter int HW     = 10,
    parameter int VW     = 10,
    parameter int IW     = 17,
    parameter int CB     = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          de,
    input logic [CB-1:0] red,
    input logic [CB-1:0] green,
    input logic [CB-1:0] blue,
    input logic          fb_ren,
    input logic [IW:0]   fb_addr,
    input logic          swap_ack,
    input logic          show_bank,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt
);

    int   hs_low, vs_low, h_period;
    logic hs_d, seen_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_low    <= 0;
            vs_low    <= 0;
            h_period  <= 0;
            hs_d      <= 1'b1;
            seen_fall <= 1'b0;
        end else begin
            hs_low <= hsync_n ? 0 : hs_low + 1;
            vs_low <= vsync_n ? 0 : vs_low + 1;
            hs_d   <= hsync_n;
            if (hs_d && !hsync_n) begin
                h_period  <= 1;
                seen_fall <= 1'b1;
            end else begin
                h_period <= h_period + 1;
            end
        end
    end

    // R2
    hsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (hs_low == H_SYNC));

    // R2
    line_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_d && !hsync_n && seen_fall) |-> (h_period == H_TOT));

    // R3
    vsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_n) |-> (vs_low == V_SYNC * H_TOT));

    // R4
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (red == '0 && green == '0 && blue == '0));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_ren && $past(fb_ren)) |->
            (fb_addr[IW-1:0] == $past(fb_addr[IW-1:0]) ||
             fb_addr[IW-1:0] == $past(fb_addr[IW-1:0]) + 1'b1));

    // R7
    bank_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_addr[IW] == show_bank) && ((show_bank != $past(show_bank)) == swap_ack));

    // R9
    ack_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |-> (h_cnt == '0 && v_cnt == VW'(V_VIS)));

endmodule

bind vga_scanout vga_scanout_chk #(
    .H_TOT  (H_VIS + H_FP + H_SYNC + H_BP),
    .H_SYNC (H_SYNC),
    .V_SYNC (V_SYNC),
    .V_VIS  (V_VIS),
    .HW     (HW),
    .VW     (VW),
    .IW     (IW),
    .CB     (COLOR_BITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_n   (hsync_n),
    .vsync_n   (vsync_n),
    .de        (de),
    .red       (red),
    .green     (green),
    .blue      (blue),
    .fb_ren    (fb_ren),
    .fb_addr   (fb_addr),
    .swap_ack  (swap_ack),
    .show_bank (show_bank),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt)
);

// File: tb/vga_scanout_test.sv
module vga_scanout_test;

    localparam int HV = 8, HF = 2, HS = 3, HB = 2;
    localparam int VV = 6, VF = 1, VS = 2, VB = 1;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int FT = HT * VT;
    localparam int SW = HV / 2;
    localparam int BANK_OFS = 16;     // 2**IW with IW = clog2(4*3) = 4
    localparam int FRAMES = 7;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       swap_req;
    logic       swap_ack, show_bank, fb_ren;
    logic [4:0] fb_addr;
    logic [8:0] fb_data;
    logic       hsync_n, vsync_n, de;
    logic [2:0] red, green, blue;

    always #5 clk = ~clk;

    vga_scanout #(
        .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .COLOR_BITS(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .swap_ack(swap_ack),
        .show_bank(show_bank), .fb_addr(fb_addr), .fb_ren(fb_ren),
        .fb_data(fb_data), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
        .red(red), .green(green), .blue(blue)
    );

    function automatic int memf(input int a);
        int t;
        t = a * 37 + 11;
        return t & 'h1FF;
    endfunction

    // Synchronous-read frame store model
    always @(posedge clk) fb_data <= 9'(memf(int'(fb_addr)));

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int bank_m, pend_m, hfall, vfall, last_hf, last_vf;
        int prev_hs, prev_vs;
        rst_n    = 1'b0;
        swap_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 hsync_n", hsync_n, 1);
        chk("R1 vsync_n", vsync_n, 1);
        chk("R1 de", de, 0);
        chk("R1 rgb", {red, green, blue}, 0);
        chk("R1 swap_ack", swap_ack, 0);
        chk("R1 show_bank", show_bank, 0);
        chk("R1 fb_addr", fb_addr, 0);
        rst_n = 1'b1;

        bank_m = 0; pend_m = 0; hfall = 0; vfall = 0;
        last_hf = 0; last_vf = 0; prev_hs = 1; prev_vs = 1;

        for (int n = 0; n < FRAMES * FT; n++) begin
            int c, hc, vc, hp, vp, exp_ren, exp_de, exp_rgb, pos, fr, rq;
            @(negedge clk);
            // counter position is one ahead of the output position
            c  = n + 1;
            hc = c % HT;
            vc = (c / HT) % VT;
            if (c % FT == VV * HT) begin
                chk("R8 ack at blank start", swap_ack, pend_m);
                if (pend_m != 0) bank_m = 1 - bank_m;
                pend_m = 0;
            end else begin
                chk("R9 ack elsewhere", swap_ack, 0);
            end
            chk("R7 show_bank", show_bank, bank_m);
            chk("R7 addr bank bit", fb_addr[4], bank_m);
            exp_ren = (hc < HV && vc < VV) ? 1 : 0;
            chk("R6 fb_ren", fb_ren, exp_ren);
            if (exp_ren != 0)
                chk("R6 fb_addr", fb_addr, bank_m * BANK_OFS + (vc / 2) * SW + hc / 2);

            hp = n % HT;
            vp = (n / HT) % VT;
            chk("R2 hsync_n", hsync_n, (hp >= HV + HF && hp < HV + HF + HS) ? 0 : 1);
            chk("R3 vsync_n", vsync_n, (vp >= VV + VF && vp < VV + VF + VS) ? 0 : 1);
            exp_de = (hp < HV && vp < VV) ? 1 : 0;
            chk("R4 de", de, exp_de);
            exp_rgb = (exp_de != 0) ? memf(bank_m * BANK_OFS + (vp / 2) * SW + hp / 2) : 0;
            if (exp_de != 0) chk("R5 rgb fields", {red, green, blue}, exp_rgb);
            else             chk("R4 black in blank", {red, green, blue}, 0);

            if (prev_hs == 1 && hsync_n == 1'b0) begin
                if (hfall > 0) chk("R2 line period", n - last_hf, HT);
                last_hf = n;
                hfall++;
            end
            if (prev_hs == 0 && hsync_n == 1'b1) chk("R2 hsync width", n - last_hf, HS);
            if (prev_vs == 1 && vsync_n == 1'b0) begin
                if (vfall > 0) chk("R3 frame period", n - last_vf, FT);
                last_vf = n;
                vfall++;
            end
            if (prev_vs == 0 && vsync_n == 1'b1) chk("R3 vsync width", n - last_vf, VS * HT);
            prev_hs = int'(hsync_n);
            prev_vs = int'(vsync_n);

            // swap request schedule, sampled by the next edge
            fr  = c / FT;
            pos = c % FT;
            rq  = ((fr == 0 && pos == 20) ||
                   (fr == 2 && (pos == 10 || pos == 50)) ||
                   (fr == 3 && pos == VV * HT - 1) ||
                   (fr == 4 && pos == 100)) ? 1 : 0;
            swap_req = rq[0];
            if (rq != 0) pend_m = 1;
        end
        swap_req = 1'b0;
        chk("R2 line count", hfall, FRAMES * VT);
        chk("R3 frame count", vfall, FRAMES);
        chk("R8 final bank", show_bank, bank_m);
        report();
    end

endmodule